// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets logic running on a single clock read and write an external asynchronous static RAM of 524,288 sixteen-bit words. The host presents one request at a time over a valid/ready handshake, carrying a read/write flag, a 19-bit word address, write data and a two-bit byte mask. Reads return their data with a one-cycle valid pulse. On the memory side the block drives the address, two chip selects of opposite polarity, active-low write and output enables, and one active-low select per byte lane. The data bus is split into an output value, an output enable and an input value, so the bidirectional pad stays outside the block.

The RAM has no clock, so every timing rule is met by counting cycles. Each count is derived from the clock period parameter as the ceiling of a nanosecond figure divided by that period. Three figures set the counts: the 70 ns access time, the 25 ns bus-release time after the memory's outputs are switched off, and a minimum write-pulse length in cycles. With the default 10 ns clock this gives 7 access cycles and 3 turnaround cycles.

Top module: `sram_ctl`

## Requirements
- R1: During reset and whenever the block is idle, it holds mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, mem_lb_n=1, mem_ub_n=1 and mem_dq_oe=0, and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the transaction is complete.
- R3: From the edge that takes a request until the end of its memory access, mem_ce1_n=0 and mem_ce2=1 and mem_addr equals the request address. mem_we_n is only ever low while both selects are active.
- R4: A read (req_we=0) holds mem_oe_n=0 and mem_we_n=1 for ACC=ceil(70 ns / clock period) cycles starting the cycle after acceptance. The data is sampled at the end of the last of these cycles and shown on rd_data during a single cycle with rd_valid=1.
- R5: Mask bit 0 enables lane 7:0 by driving mem_lb_n low, and mask bit 1 enables lane 15:8 by driving mem_ub_n low. A write leaves a disabled lane's stored byte unchanged. A read returns 0 in a disabled lane.
- R6: A write (req_we=1) takes one setup cycle with mem_we_n=1, then WP cycles (default 5) with mem_we_n=0, then one hold cycle with mem_we_n=1. The address and the lane selects do not change during this sequence.
- R7: mem_dq_oe is 1 only during the write pulse and the hold cycle that follows it, then carries the write data on mem_dq_out. It is never 1 while mem_oe_n is 0.
- R8: After a read's access cycles, the block deselects the memory and stays busy for TA=ceil(25 ns / clock period) further cycles. It drives the bus no sooner than 25 ns after the memory stopped driving.
- R9: req_ready returns ACC+TA cycles after a read is accepted and WP+2 cycles after a write is accepted. Data written to any address, including 0 and 7FFFF hex, reads back.
- R10: rd_valid is a single-cycle pulse and occurs only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = lane 7:0, bit 1 = lane 15:8 |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lb_n | output | 1 | Active-low lane 7:0 select |
| mem_ub_n | output | 1 | Active-low lane 15:8 select |
| mem_dq_out | output | 16 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus driver enable |
| mem_dq_in | input | 16 | Data seen on the memory bus |

## Verification
On every cycle the assertions check the following pin-level invariants: write enable only with both selects active, no driving while output enable is low, a gap of at least the turnaround count since output enable was last low, a stable address and lane selects through the write pulse, data still driven in the cycle write enable rises, a fully deselected bus while ready, and single-cycle read pulses. Other behaviour depends on the memory's contents and timing, and only the bench's scenarios can show it. This covers the exact cycle counts of each phase, lane merging across partial writes, zeroing of disabled read lanes, correct read data under a memory model that returns unknown values until 70 ns after its last input change, and back-to-back read-to-write sequences where bus contention would show up.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } sram_st_e;

  // Whole clock cycles covering a span given in nanoseconds (at least 1).
  function automatic int cyc_ceil(input int span_ns, input int clk_ns);
    int c;
    c = (span_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
`timescale 1ns/1ps
module sram_ctl_lanes #(
  parameter int AW = 19,
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [AW-1:0]    in_addr,
  input  logic [DW-1:0]    in_wdata,
  input  logic [LANES-1:0] in_be,
  input  logic             grab,
  input  logic [DW-1:0]    bus_in,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [LANES-1:0] be_q,
  output logic [DW-1:0]    rdata_q
);

  logic [DW-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (take) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      be_q    <= in_be;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata_d[g*8 +: 8] = be_q[g] ? bus_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (grab) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl #(
  parameter int CLK_NS    = 10,
  parameter int ACC_NS    = 70,
  parameter int REL_NS    = 25,
  parameter int WP_CYC    = 5,
  parameter int AW        = 19,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  import sram_ctl_pkg::*;

  localparam int LANES   = DW / 8;
  localparam int ACC_CYC = cyc_ceil(ACC_NS, CLK_NS);
  localparam int TA_CYC  = cyc_ceil(REL_NS, CLK_NS);
  localparam int MAXC    = (ACC_CYC > WP_CYC) ? ((ACC_CYC > TA_CYC) ? ACC_CYC : TA_CYC)
                                              : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
  localparam int TW      = (MAXC > 1) ? $clog2(MAXC) : 1;

  sram_st_e st_q, st_d;
  logic          accept;
  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_done;
  logic          grab;

  logic             sel_d, oe_n_d, we_n_d, drv_d;
  logic [LANES-1:0] lane_n_d, lane_n_q;
  logic             ce1_n_q, ce2_q, we_n_q, oe_n_q, drv_q, rdv_q;

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_eff;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Next-state and timer control
  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    grab   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_we) begin
            st_d = ST_WSETUP;
          end else begin
            st_d   = ST_READ;
            t_load = 1'b1;
            t_val  = TW'(ACC_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (t_done) begin
          st_d   = ST_TURN;
          grab   = 1'b1;
          t_load = 1'b1;
          t_val  = TW'(TA_CYC - 1);
        end
      end
      ST_TURN: begin
        if (t_done) st_d = ST_IDLE;
      end
      ST_WSETUP: begin
        st_d   = ST_WPULSE;
        t_load = 1'b1;
        t_val  = TW'(WP_CYC - 1);
      end
      ST_WPULSE: begin
        if (t_done) st_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Pin values for the coming cycle, decoded from the next state
  assign be_eff = accept ? req_be : be_q;

  always_comb begin
    sel_d    = (st_d == ST_READ) || (st_d == ST_WSETUP) ||
               (st_d == ST_WPULSE) || (st_d == ST_WHOLD);
    oe_n_d   = (st_d != ST_READ);
    we_n_d   = (st_d != ST_WPULSE);
    drv_d    = (st_d == ST_WPULSE) || (st_d == ST_WHOLD);
    lane_n_d = sel_d ? ~be_eff : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ce1_n_q  <= 1'b1;
      ce2_q    <= 1'b0;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      drv_q    <= 1'b0;
      lane_n_q <= '1;
      rdv_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      ce1_n_q  <= ~sel_d;
      ce2_q    <= sel_d;
      we_n_q   <= we_n_d;
      oe_n_q   <= oe_n_d;
      drv_q    <= drv_d;
      lane_n_q <= lane_n_d;
      rdv_q    <= grab;
    end
  end

  sram_ctl_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  sram_ctl_lanes #(.AW(AW), .DW(DW)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_be    (req_be),
    .grab     (grab),
    .bus_in   (mem_dq_in),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .be_q     (be_q),
    .rdata_q  (rd_data)
  );

  assign rd_valid   = rdv_q;
  assign mem_addr   = addr_q;
  assign mem_ce1_n  = ce1_n_q;
  assign mem_ce2    = ce2_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_lb_n   = lane_n_q[0];
  assign mem_ub_n   = lane_n_q[LANES-1];
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drv_q;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int CLK_NS = 10,
  parameter int REL_NS = 25,
  parameter int AW     = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce1_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe
);
  import sram_ctl_pkg::*;

  localparam int TA  = cyc_ceil(REL_NS, CLK_NS);
  localparam int GW  = $clog2(TA + 2) + 1;
  localparam logic [GW-1:0] GMAX = GW'(TA + 1);

  // Cycles since the memory output enable was last low (saturating)
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GMAX;
    end else if (!mem_oe_n) begin
      gap_q <= '0;
    end else if (gap_q != GMAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && mem_lb_n && mem_ub_n)); // R1

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2)); // R3

  AST_RDV_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n)); // R4

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n))); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && !mem_ce1_n)); // R6

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (gap_q >= GW'(TA))); // R8

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R10

endmodule

bind sram_ctl sram_ctl_chk #(.CLK_NS(CLK_NS), .REL_NS(REL_NS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;

  localparam int TCLK = 20;
  localparam int ACC  = (70 + TCLK - 1) / TCLK;
  localparam int TA   = (25 + TCLK - 1) / TCLK;
  localparam int WP   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] bus;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  sram_ctl #(.CLK_NS(TCLK), .WP_CYC(WP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(bus)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [15:0] marr [int];
  logic [15:0] mdata;
  logic        mvalid = 1'b0;
  int          tok = 0;
  bit          wtick = 1'b0;
  real         t_rel = -1000.0;
  logic        msel, mdrv_lo, mdrv_hi, mdrv;

  function automatic logic [15:0] rd_word(input int a);
    return marr.exists(a) ? marr[a] : 16'h0000;
  endfunction

  task automatic arm(input int t);
    fork
      begin
        #70;
        if (tok == t) mvalid = 1'b1;
      end
    join_none
  endtask

  always @(mem_addr or mem_ce1_n or mem_ce2 or mem_oe_n or mem_lb_n or mem_ub_n or mem_we_n) begin
    tok = tok + 1;
    mvalid = 1'b0;
    arm(tok);
  end

  always @(mem_addr or wtick) mdata = rd_word(int'(mem_addr));

  always @* begin
    msel    = !mem_ce1_n && mem_ce2;
    mdrv_lo = msel && !mem_oe_n && mem_we_n && !mem_lb_n;
    mdrv_hi = msel && !mem_oe_n && mem_we_n && !mem_ub_n;
    mdrv    = mdrv_lo || mdrv_hi;
    if (mem_dq_oe && mdrv_lo)  bus[7:0] = 8'hxx;
    else if (mem_dq_oe)        bus[7:0] = mem_dq_out[7:0];
    else if (mdrv_lo)          bus[7:0] = mvalid ? mdata[7:0] : 8'hxx;
    else                       bus[7:0] = 8'hzz;
    if (mem_dq_oe && mdrv_hi)  bus[15:8] = 8'hxx;
    else if (mem_dq_oe)        bus[15:8] = mem_dq_out[15:8];
    else if (mdrv_hi)          bus[15:8] = mvalid ? mdata[15:8] : 8'hxx;
    else                       bus[15:8] = 8'hzz;
  end

  always @(negedge mdrv) t_rel = $realtime;

  always @(posedge mem_we_n) begin
    if (!mem_ce1_n && mem_ce2) begin
      logic [15:0] w;
      w = rd_word(int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = bus[7:0];
      if (!mem_ub_n) w[15:8] = bus[15:8];
      marr[int'(mem_addr)] = w;
      wtick = ~wtick;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [15:0] shadow [int];
  bit          act = 1'b0;
  int          k = 0;
  int          total = 0;
  int          n_acc = 0;
  bit          t_we;
  logic [18:0] t_addr;
  logic [1:0]  t_be;
  logic [15:0] t_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      act = 1'b0;
      k   = 0;
    end else if (act) begin
      k = k + 1;
      if (k > total) act = 1'b0;
    end else if (req_valid) begin
      logic [15:0] cur;
      act    = 1'b1;
      k      = 1;
      t_we   = req_we;
      t_addr = req_addr;
      t_be   = req_be;
      cur    = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 16'h0000;
      if (req_we) begin
        total = WP + 2;
        if (req_be[0]) cur[7:0]  = req_wdata[7:0];
        if (req_be[1]) cur[15:8] = req_wdata[15:8];
        shadow[int'(req_addr)] = cur;
      end else begin
        total = ACC + TA;
        t_exp = {req_be[1] ? cur[15:8] : 8'h00, req_be[0] ? cur[7:0] : 8'h00};
      end
      n_acc = n_acc + 1;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && req_ready,
          "R1 reset pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready}, 8'b10111101);
    end else begin
      bit sel_e, oe_lo_e, we_lo_e, drv_e, rdv_e;
      logic [1:0] lanes_e;
      sel_e   = act && (t_we ? (k <= WP + 2) : (k <= ACC));
      oe_lo_e = act && !t_we && (k <= ACC);
      we_lo_e = act && t_we && (k >= 2) && (k <= WP + 1);
      drv_e   = act && t_we && (k >= 2) && (k <= WP + 2);
      rdv_e   = act && !t_we && (k == ACC + 1);
      lanes_e = sel_e ? ~t_be : 2'b11;
      chk(req_ready == !act, "R2 req_ready", req_ready, !act);
      chk(!act ? (mem_ce1_n && !mem_ce2) : 1'b1, "R1 idle deselect", {mem_ce1_n, mem_ce2}, 2'b10);
      chk((mem_ce1_n == !sel_e) && (mem_ce2 == sel_e), "R3 chip selects", {mem_ce1_n, mem_ce2}, {!sel_e, sel_e});
      if (sel_e) chk(mem_addr == t_addr, "R3 address", mem_addr, t_addr);
      chk(mem_oe_n == !oe_lo_e, "R4 output enable", mem_oe_n, !oe_lo_e);
      chk(mem_we_n == !we_lo_e, "R6 write enable", mem_we_n, !we_lo_e);
      chk({mem_ub_n, mem_lb_n} == lanes_e, "R5 lane selects", {mem_ub_n, mem_lb_n}, lanes_e);
      chk(mem_dq_oe == drv_e, "R7 driver enable", mem_dq_oe, drv_e);
      if (mem_dq_oe) chk(($realtime - t_rel) >= 25.0, "R8 bus turnaround", int'($realtime - t_rel), 25);
      chk(rd_valid == rdv_e, "R10 rd_valid timing", rd_valid, rdv_e);
      if (rdv_e) chk(rd_data === t_exp, "R4 R5 R9 read data", rd_data, t_exp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit we, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    int c0;
    c0 = n_acc;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    while (n_acc == c0) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (act) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * TCLK);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 full-word write and read at address 0
    do_req(1'b1, 19'h00000, 16'h1234, 2'b11);
    settle();
    do_req(1'b0, 19'h00000, 16'h0000, 2'b11);
    settle();

    // R5 lane-only writes at the top address, partial reads
    do_req(1'b1, 19'h7FFFF, 16'hA5C3, 2'b01);
    settle();
    do_req(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    settle();
    do_req(1'b1, 19'h7FFFF, 16'h5AFF, 2'b10);
    settle();
    do_req(1'b0, 19'h7FFFF, 16'h0000, 2'b01);
    settle();
    do_req(1'b0, 19'h7FFFF, 16'h0000, 2'b10);
    settle();

    // R5 empty mask changes nothing
    do_req(1'b1, 19'h00000, 16'hFFFF, 2'b00);
    settle();
    do_req(1'b0, 19'h00000, 16'h0000, 2'b11);
    settle();

    // R8 back-to-back read then write then read
    do_req(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    do_req(1'b1, 19'h2AAAA, 16'hBEEF, 2'b11);
    do_req(1'b0, 19'h2AAAA, 16'h0000, 2'b11);
    do_req(1'b1, 19'h15555, 16'h0F0F, 2'b11);
    do_req(1'b0, 19'h15555, 16'h0000, 2'b10);
    settle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule